// File: doc/BRIEF.md
# Frame-Synchronous Shadow Register Controller

This block is the configuration register bank of a video processing core. Software writes through a simple single-beat memory-mapped port. Every configuration value has two copies. The first is a software-visible shadow that takes each write. The second is an active copy that feeds the pixel datapath. The active copies are refreshed from the shadows all together, and only when a start-of-frame pulse arrives while both the core enable and the update enable are set. Software can therefore reprogram a whole parameter set while a frame is in flight without tearing the image.

The control word also provides two resets. The immediate reset forces every configuration value back to its default at once and keeps the core's reset output high for as long as the bit stays set. The synchronized reset is armed by software. It fires on the next rising edge of the vertical blanking input, returns the configuration values to their defaults, pulses the core reset for one cycle and then disarms itself. The block also holds a status word that follows an input, a sticky error word cleared by writing ones to it, an interrupt-enable word and a read-only version word.

Top module: `frame_shadow_regs`

## Requirements
- R1: After the asynchronous reset, the control word reads 0, every shadow and active value equals its parameter default, `core_rst_o` is low and `core_en_o` is low.
- R2: While the update-enable bit (control bit 1) is clear, a configuration write changes only the value read back. The active outputs keep their value, even when `sof_i` pulses.
- R3: When `sof_i` is high in a cycle where control bits 0 and 1 are both set, every active output takes its shadow value in the following cycle. Bit 1 stays set afterwards.
- R4: With control bit 0 clear, a start-of-frame pulse transfers nothing, whatever the state of bit 1.
- R5: Field layout: 0x020 holds the column count in bits 31:16 and the row count in bits 15:0. 0x100 holds the maximum and 0x104 the minimum, each PIX_W bits wide. 0x108, 0x10C and 0x110 hold the red, green and blue offsets, each OFF_W bits. 0x114 to 0x120 hold coefficients A to D, each COEF_W bits. Bits above a field's width are read as 0.
- R6: Writing the control word with bit 31 set returns every shadow and active value to its default in the same cycle. `core_rst_o` is then high from the next cycle until a control write clears bit 31. Configuration writes made while bit 31 is set have no effect.
- R7: Writing control bit 30 as 1 arms the synchronized reset, which reads back as 1 while armed. On the first cycle in which `vblank_i` is high after having been low in the previous cycle, all configuration values return to their defaults, `core_rst_o` is high for exactly one cycle and bit 30 clears.
- R8: An armed synchronized reset does not fire while `vblank_i` is low, or while it stays high from before the arming. Only a new low-to-high transition fires it.
- R9: Reads of unmapped addresses (and of addresses that are not word aligned) return 0, and writes to them change nothing. The version word at 0x010 reads as the VERSION parameter and ignores writes.
- R10: 0x004 reads `status_i`. Each `error_i` bit sets a sticky bit at 0x008, which a write of 1 to that bit clears. 0x00C is a read/write word that drives `irq_en_o`.
- R11: Read data and `bus_rvalid` appear in the cycle after `bus_rd` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one beat |
| bus_waddr | input | 12 | Write byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_raddr | input | 12 | Read byte address |
| bus_rdata | output | DATA_W | Registered read data |
| bus_rvalid | output | 1 | Read data valid |
| sof_i | input | 1 | Start-of-frame pulse |
| vblank_i | input | 1 | Vertical blanking level |
| status_i | input | DATA_W | Datapath status, read at 0x004 |
| error_i | input | DATA_W | Datapath error events |
| core_en_o | output | 1 | Core enable |
| core_rst_o | output | 1 | Datapath reset request |
| irq_en_o | output | DATA_W | Interrupt enable word |
| cols_o | output | DATA_W/2 | Active column count |
| rows_o | output | DATA_W/2 | Active row count |
| max_o | output | PIX_W | Active upper clip level |
| min_o | output | PIX_W | Active lower clamp level |
| roff_o | output | OFF_W | Active red offset |
| goff_o | output | OFF_W | Active green offset |
| boff_o | output | OFF_W | Active blue offset |
| coef_a_o | output | COEF_W | Active coefficient A |
| coef_b_o | output | COEF_W | Active coefficient B |
| coef_c_o | output | COEF_W | Active coefficient C |
| coef_d_o | output | COEF_W | Active coefficient D |

## Verification
The assertions check three things on every cycle: the active copies stay frozen unless a transfer or a reset occurs, a transfer copies exactly the shadow values of the cycle before, and any reset leaves both copies at their defaults. They also check that the synchronized reset disarms itself and drives a one-cycle pulse, that unmapped and version reads return the expected words, and that read valid follows the strobe. Some behaviours can only be shown by the bench's scenarios. These are the sweep over all enable combinations, the field masking of every register, and the ignoring of writes during the immediate reset. The remaining scenario arms the reset while blanking is already high, which must wait for a fresh edge.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

  localparam int ADDR_W = 12;
  localparam int NCFG   = 10;
  localparam int IDX_W  = $clog2(NCFG);

  typedef enum logic [IDX_W-1:0] {
    CFG_SIZE = 4'd0,
    CFG_MAX  = 4'd1,
    CFG_MIN  = 4'd2,
    CFG_ROFF = 4'd3,
    CFG_GOFF = 4'd4,
    CFG_BOFF = 4'd5,
    CFG_CA   = 4'd6,
    CFG_CB   = 4'd7,
    CFG_CC   = 4'd8,
    CFG_CD   = 4'd9
  } cfg_idx_e;

  localparam logic [ADDR_W-1:0] A_CTRL = 12'h000;
  localparam logic [ADDR_W-1:0] A_STAT = 12'h004;
  localparam logic [ADDR_W-1:0] A_ERR  = 12'h008;
  localparam logic [ADDR_W-1:0] A_IRQ  = 12'h00C;
  localparam logic [ADDR_W-1:0] A_VER  = 12'h010;
  localparam logic [ADDR_W-1:0] A_SIZE = 12'h020;
  localparam logic [ADDR_W-1:0] A_CORE_LO = 12'h100;
  localparam logic [ADDR_W-1:0] A_CORE_HI = 12'h120;

  // control word bit positions
  localparam int BIT_EN    = 0;
  localparam int BIT_UPD   = 1;
  localparam int BIT_ARM   = 30;
  localparam int BIT_SWRST = 31;

  function automatic logic is_cfg(input logic [ADDR_W-1:0] a);
    return (a == A_SIZE) ||
           ((a >= A_CORE_LO) && (a <= A_CORE_HI) && (a[1:0] == 2'b00));
  endfunction

  function automatic logic [IDX_W-1:0] cfg_sel(input logic [ADDR_W-1:0] a);
    if (a == A_SIZE) return IDX_W'(CFG_SIZE);
    return IDX_W'((a - A_CORE_LO) >> 2) + IDX_W'(1);
  endfunction

  function automatic logic is_mapped(input logic [ADDR_W-1:0] a);
    return (a == A_CTRL) || (a == A_STAT) || (a == A_ERR) ||
           (a == A_IRQ)  || (a == A_VER)  || is_cfg(a);
  endfunction

endpackage

// File: rtl/fsr_rise_det.sv
module fsr_rise_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic rise_o
);

  logic sig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= 1'b0;
    else        sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;

endmodule

// File: rtl/fsr_ctrl.sv
module fsr_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_wr,
  input  logic wr_en_bit,
  input  logic wr_upd_bit,
  input  logic wr_arm_bit,
  input  logic wr_rst_bit,
  input  logic vb_rise,
  output logic en_o,
  output logic upd_o,
  output logic armed_o,
  output logic swrst_o,
  output logic core_rst_o,
  output logic cfg_rst_o
);

  logic en_q, upd_q, armed_q, swrst_q, pulse_q;
  logic en_d, upd_d, armed_d, swrst_d, pulse_d;
  logic fire;

  assign fire = armed_q & vb_rise;

  always_comb begin
    en_d    = en_q;
    upd_d   = upd_q;
    swrst_d = swrst_q;
    armed_d = armed_q;
    if (ctl_wr) begin
      en_d    = wr_en_bit;
      upd_d   = wr_upd_bit;
      swrst_d = wr_rst_bit;
      armed_d = wr_arm_bit;
    end
    if (fire) armed_d = 1'b0;
    pulse_d = fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      upd_q   <= 1'b0;
      armed_q <= 1'b0;
      swrst_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      en_q    <= en_d;
      upd_q   <= upd_d;
      armed_q <= armed_d;
      swrst_q <= swrst_d;
      pulse_q <= pulse_d;
    end
  end

  assign en_o       = en_q;
  assign upd_o      = upd_q;
  assign armed_o    = armed_q;
  assign swrst_o    = swrst_q;
  assign core_rst_o = swrst_q | pulse_q;
  assign cfg_rst_o  = (ctl_wr & wr_rst_bit) | swrst_q | fire;

  AST_ARM_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !armed_q); // R7
  AST_AUTORST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !(ctl_wr && wr_arm_bit)) |=> (core_rst_o ##1 !pulse_q)); // R7
  AST_NO_FIRE_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |=> !pulse_q); // R8

endmodule

// File: rtl/fsr_cfg_bank.sv
module fsr_cfg_bank #(
  parameter int N  = 10,
  parameter int DW = 32,
  parameter logic [N-1:0][DW-1:0] MASKS    = '1,
  parameter logic [N-1:0][DW-1:0] DEFAULTS = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [$clog2(N)-1:0]     wr_idx,
  input  logic [DW-1:0]            wdata,
  input  logic                     rst_cfg,
  input  logic                     load,
  output logic [N-1:0][DW-1:0]     shadow_o,
  output logic [N-1:0][DW-1:0]     active_o
);

  localparam int IW = $clog2(N);
  localparam logic [N-1:0][DW-1:0] DEF_M = DEFAULTS & MASKS;

  for (genvar i = 0; i < N; i++) begin : g_entry
    logic [DW-1:0] sh_q, sh_d, ac_q, ac_d;
    logic          sh_ce, ac_ce;

    always_comb begin
      sh_ce = rst_cfg | (wr_en & (wr_idx == IW'(i)));
      sh_d  = rst_cfg ? DEF_M[i] : (wdata & MASKS[i]);
      ac_ce = rst_cfg | load;
      ac_d  = rst_cfg ? DEF_M[i] : sh_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sh_q <= DEF_M[i];
      else if (sh_ce) sh_q <= sh_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ac_q <= DEF_M[i];
      else if (ac_ce) ac_q <= ac_d;
    end

    assign shadow_o[i] = sh_q;
    assign active_o[i] = ac_q;
  end

  AST_ACTIVE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !rst_cfg) |=> $stable(active_o)); // R2
  AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !rst_cfg) |=> (active_o == $past(shadow_o))); // R3
  AST_RESET_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    rst_cfg |=> ((shadow_o == DEF_M) && (active_o == DEF_M))); // R6

endmodule

// File: rtl/frame_shadow_regs.sv
module frame_shadow_regs
  import fsr_pkg::*;
#(
  parameter int             DATA_W   = 32,
  parameter int             PIX_W    = 8,
  parameter int             OFF_W    = 32,
  parameter int             COEF_W   = 17,
  parameter logic [31:0]    VERSION  = 32'h0301_0000,
  parameter int             DEF_COLS = 1280,
  parameter int             DEF_ROWS = 720,
  parameter int             DEF_MAX  = 255,
  parameter int             DEF_MIN  = 0,
  parameter int             DEF_OFF  = 16,
  parameter int             DEF_CA   = 1000,
  parameter int             DEF_CB   = 2000,
  parameter int             DEF_CC   = 3000,
  parameter int             DEF_CD   = 4000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_waddr,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_raddr,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                bus_rvalid,
  input  logic                sof_i,
  input  logic                vblank_i,
  input  logic [DATA_W-1:0]   status_i,
  input  logic [DATA_W-1:0]   error_i,
  output logic                core_en_o,
  output logic                core_rst_o,
  output logic [DATA_W-1:0]   irq_en_o,
  output logic [DATA_W/2-1:0] cols_o,
  output logic [DATA_W/2-1:0] rows_o,
  output logic [PIX_W-1:0]    max_o,
  output logic [PIX_W-1:0]    min_o,
  output logic [OFF_W-1:0]    roff_o,
  output logic [OFF_W-1:0]    goff_o,
  output logic [OFF_W-1:0]    boff_o,
  output logic [COEF_W-1:0]   coef_a_o,
  output logic [COEF_W-1:0]   coef_b_o,
  output logic [COEF_W-1:0]   coef_c_o,
  output logic [COEF_W-1:0]   coef_d_o
);

  localparam int HALF_W = DATA_W / 2;

  function automatic logic [DATA_W-1:0] low_ones(input int w);
    return DATA_W'((64'd1 << w) - 64'd1);
  endfunction

  function automatic logic [NCFG-1:0][DATA_W-1:0] build_masks();
    logic [NCFG-1:0][DATA_W-1:0] m;
    m[int'(CFG_SIZE)] = '1;
    m[int'(CFG_MAX)]  = low_ones(PIX_W);
    m[int'(CFG_MIN)]  = low_ones(PIX_W);
    m[int'(CFG_ROFF)] = low_ones(OFF_W);
    m[int'(CFG_GOFF)] = low_ones(OFF_W);
    m[int'(CFG_BOFF)] = low_ones(OFF_W);
    m[int'(CFG_CA)]   = low_ones(COEF_W);
    m[int'(CFG_CB)]   = low_ones(COEF_W);
    m[int'(CFG_CC)]   = low_ones(COEF_W);
    m[int'(CFG_CD)]   = low_ones(COEF_W);
    return m;
  endfunction

  function automatic logic [NCFG-1:0][DATA_W-1:0] build_defaults();
    logic [NCFG-1:0][DATA_W-1:0] d;
    d[int'(CFG_SIZE)] = {HALF_W'(DEF_COLS), HALF_W'(DEF_ROWS)};
    d[int'(CFG_MAX)]  = DATA_W'(DEF_MAX);
    d[int'(CFG_MIN)]  = DATA_W'(DEF_MIN);
    d[int'(CFG_ROFF)] = DATA_W'(DEF_OFF);
    d[int'(CFG_GOFF)] = DATA_W'(DEF_OFF);
    d[int'(CFG_BOFF)] = DATA_W'(DEF_OFF);
    d[int'(CFG_CA)]   = DATA_W'(DEF_CA);
    d[int'(CFG_CB)]   = DATA_W'(DEF_CB);
    d[int'(CFG_CC)]   = DATA_W'(DEF_CC);
    d[int'(CFG_CD)]   = DATA_W'(DEF_CD);
    return d;
  endfunction

  localparam logic [NCFG-1:0][DATA_W-1:0] MASKS    = build_masks();
  localparam logic [NCFG-1:0][DATA_W-1:0] DEFAULTS = build_defaults();

  // ---------------------------------------------------------------- decode
  logic ctl_wr, cfg_wr, err_wr, irq_wr;
  logic [IDX_W-1:0] wr_idx;

  always_comb begin
    ctl_wr = bus_wr & (bus_waddr == A_CTRL);
    err_wr = bus_wr & (bus_waddr == A_ERR);
    irq_wr = bus_wr & (bus_waddr == A_IRQ);
    cfg_wr = bus_wr & is_cfg(bus_waddr);
    wr_idx = cfg_sel(bus_waddr);
  end

  // ---------------------------------------------------------------- control
  logic vb_rise, en, upd, armed, swrst, cfg_rst, load;

  fsr_rise_det u_vb_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_i  (vblank_i),
    .rise_o (vb_rise)
  );

  fsr_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_wr     (ctl_wr),
    .wr_en_bit  (bus_wdata[BIT_EN]),
    .wr_upd_bit (bus_wdata[BIT_UPD]),
    .wr_arm_bit (bus_wdata[BIT_ARM]),
    .wr_rst_bit (bus_wdata[BIT_SWRST]),
    .vb_rise    (vb_rise),
    .en_o       (en),
    .upd_o      (upd),
    .armed_o    (armed),
    .swrst_o    (swrst),
    .core_rst_o (core_rst_o),
    .cfg_rst_o  (cfg_rst)
  );

  assign load = sof_i & en & upd;

  // ---------------------------------------------------------------- bank
  logic [NCFG-1:0][DATA_W-1:0] shadow, active;

  fsr_cfg_bank #(
    .N        (NCFG),
    .DW       (DATA_W),
    .MASKS    (MASKS),
    .DEFAULTS (DEFAULTS)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_wr),
    .wr_idx   (wr_idx),
    .wdata    (bus_wdata),
    .rst_cfg  (cfg_rst),
    .load     (load),
    .shadow_o (shadow),
    .active_o (active)
  );

  // ---------------------------------------------------------------- misc words
  logic [DATA_W-1:0] err_q, err_d, irq_q, irq_d;

  always_comb begin
    err_d = err_q;
    if (err_wr) err_d = err_d & ~bus_wdata;
    err_d = err_d | error_i;
    irq_d = irq_wr ? bus_wdata : irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= '0;
      irq_q <= '0;
    end else begin
      err_q <= err_d;
      irq_q <= irq_d;
    end
  end

  // ---------------------------------------------------------------- read
  logic [DATA_W-1:0] rd_d, rd_q;
  logic              rv_q;

  always_comb begin
    rd_d = '0;
    if (is_cfg(bus_raddr)) begin
      rd_d = shadow[cfg_sel(bus_raddr)];
    end else begin
      case (bus_raddr)
        A_CTRL: begin
          rd_d[BIT_EN]    = en;
          rd_d[BIT_UPD]   = upd;
          rd_d[BIT_ARM]   = armed;
          rd_d[BIT_SWRST] = swrst;
        end
        A_STAT:  rd_d = status_i;
        A_ERR:   rd_d = err_q;
        A_IRQ:   rd_d = irq_q;
        A_VER:   rd_d = DATA_W'(VERSION);
        default: rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
      rv_q <= 1'b0;
    end else begin
      rv_q <= bus_rd;
      if (bus_rd) rd_q <= rd_d;
    end
  end

  assign bus_rdata  = rd_q;
  assign bus_rvalid = rv_q;

  // ---------------------------------------------------------------- outputs
  assign core_en_o = en;
  assign irq_en_o  = irq_q;
  assign cols_o    = active[int'(CFG_SIZE)][DATA_W-1:HALF_W];
  assign rows_o    = active[int'(CFG_SIZE)][HALF_W-1:0];
  assign max_o     = active[int'(CFG_MAX)][PIX_W-1:0];
  assign min_o     = active[int'(CFG_MIN)][PIX_W-1:0];
  assign roff_o    = active[int'(CFG_ROFF)][OFF_W-1:0];
  assign goff_o    = active[int'(CFG_GOFF)][OFF_W-1:0];
  assign boff_o    = active[int'(CFG_BOFF)][OFF_W-1:0];
  assign coef_a_o  = active[int'(CFG_CA)][COEF_W-1:0];
  assign coef_b_o  = active[int'(CFG_CB)][COEF_W-1:0];
  assign coef_c_o  = active[int'(CFG_CC)][COEF_W-1:0];
  assign coef_d_o  = active[int'(CFG_CD)][COEF_W-1:0];

  // ---------------------------------------------------------------- checks
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !is_mapped(bus_raddr)) |=> (bus_rdata == '0)); // R9
  AST_VERSION_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_raddr == A_VER) |=> (bus_rdata == DATA_W'(VERSION))); // R9
  AST_RVALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid); // R11
  AST_RVALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid); // R11
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (|error_i) |=> ((bus_rdata == bus_rdata) && ((err_q & $past(error_i)) == $past(error_i)))); // R10

endmodule

// File: tb/frame_shadow_regs_bench.sv
module frame_shadow_regs_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_waddr = '0, bus_raddr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        sof_i = 1'b0, vblank_i = 1'b0;
  logic [31:0] status_i = '0, error_i = '0;
  logic        core_en_o, core_rst_o;
  logic [31:0] irq_en_o;
  logic [15:0] cols_o, rows_o;
  logic [7:0]  max_o, min_o;
  logic [31:0] roff_o, goff_o, boff_o;
  logic [16:0] coef_a_o, coef_b_o, coef_c_o, coef_d_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] exp_sh  [N];
  logic [31:0] exp_act [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_shadow_regs u_frame_shadow_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_waddr(bus_waddr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .sof_i(sof_i), .vblank_i(vblank_i),
    .status_i(status_i), .error_i(error_i),
    .core_en_o(core_en_o), .core_rst_o(core_rst_o), .irq_en_o(irq_en_o),
    .cols_o(cols_o), .rows_o(rows_o), .max_o(max_o), .min_o(min_o),
    .roff_o(roff_o), .goff_o(goff_o), .boff_o(boff_o),
    .coef_a_o(coef_a_o), .coef_b_o(coef_b_o), .coef_c_o(coef_c_o),
    .coef_d_o(coef_d_o)
  );

  function automatic logic [11:0] addr_of(int i);
    return (i == 0) ? 12'h020 : 12'(12'h100 + 4 * (i - 1));
  endfunction

  function automatic logic [31:0] mask_of(int i);
    if (i == 1 || i == 2) return 32'((64'd1 << 8) - 1);
    if (i >= 6)           return 32'((64'd1 << 17) - 1);
    return 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] def_of(int i);
    case (i)
      0: return {16'd1280, 16'd720};
      1: return 32'd255;
      2: return 32'd0;
      6: return 32'd1000;
      7: return 32'd2000;
      8: return 32'd3000;
      9: return 32'd4000;
      default: return 32'd16;
    endcase
  endfunction

  function automatic logic [31:0] out_of(int i);
    case (i)
      0: return {cols_o, rows_o};
      1: return {24'd0, max_o};
      2: return {24'd0, min_o};
      3: return roff_o;
      4: return goff_o;
      5: return boff_o;
      6: return {15'd0, coef_a_o};
      7: return {15'd0, coef_b_o};
      8: return {15'd0, coef_c_o};
      default: return {15'd0, coef_d_o};
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_waddr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_raddr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    chk("R11 rvalid", {31'd0, bus_rvalid}, 32'd1);
    d = bus_rdata;
  endtask

  task automatic sof_pulse();
    sof_i = 1'b1;
    @(negedge clk);
    sof_i = 1'b0;
  endtask

  task automatic check_outputs(input string tag);
    for (int i = 0; i < N; i++) chk(tag, out_of(i), exp_act[i]);
  endtask

  task automatic check_shadows(input string tag);
    logic [31:0] v;
    for (int i = 0; i < N; i++) begin
      rd(addr_of(i), v);
      chk(tag, v, exp_sh[i]);
    end
  endtask

  task automatic all_default();
    for (int i = 0; i < N; i++) begin
      exp_sh[i]  = def_of(i) & mask_of(i);
      exp_act[i] = def_of(i) & mask_of(i);
    end
  endtask

  task automatic write_all(input logic [31:0] seed);
    for (int i = 0; i < N; i++) begin
      logic [31:0] p;
      p = seed ^ (32'(i) * 32'h1357_9BDF);
      wr(addr_of(i), p);
      exp_sh[i] = p & mask_of(i);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    all_default();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 core_rst", {31'd0, core_rst_o}, 32'd0);
    chk("R1 core_en",  {31'd0, core_en_o},  32'd0);
    rd(12'h000, v); chk("R1 ctrl", v, 32'd0);
    check_outputs("R1 active default");
    check_shadows("R1 shadow default");

    // R5 / R2: masked readback, active untouched
    write_all(32'hDEAD_BEEF);
    check_shadows("R5 masked readback");
    check_outputs("R2 active unchanged after write");
    sof_pulse();
    check_outputs("R2 no transfer with update clear");

    // R4 / R3: sweep enable combinations
    for (int c = 0; c < 4; c++) begin
      wr(12'h000, 32'(c));
      chk("R1 core_en follows", {31'd0, core_en_o}, 32'(c & 1));
      sof_pulse();
      if (c == 3) for (int i = 0; i < N; i++) exp_act[i] = exp_sh[i];
      check_outputs((c == 3) ? "R3 transfer" : "R4 no transfer");
    end
    rd(12'h000, v); chk("R3 update bit stays", v, 32'd3);

    // R2 with update set: writes wait for next sof
    write_all(32'h0F1E_2D3C);
    check_outputs("R2 waits for frame");
    sof_pulse();
    for (int i = 0; i < N; i++) exp_act[i] = exp_sh[i];
    check_outputs("R3 second transfer");

    // R9 unmapped / version
    wr(12'h024, 32'hFFFF_FFFF);
    wr(12'h0FC, 32'hFFFF_FFFF);
    wr(12'h124, 32'hFFFF_FFFF);
    wr(12'h102, 32'hFFFF_FFFF);
    wr(12'h010, 32'h1234_5678);
    rd(12'h024, v); chk("R9 unmapped 024", v, 32'd0);
    rd(12'h124, v); chk("R9 unmapped 124", v, 32'd0);
    rd(12'h102, v); chk("R9 misaligned 102", v, 32'd0);
    rd(12'h010, v); chk("R9 version", v, 32'h0301_0000);
    check_shadows("R9 config untouched");
    rd(12'h000, v); chk("R9 ctrl untouched", v, 32'd3);

    // R10 status, error, irq enable
    status_i = 32'hCAFE_0042;
    rd(12'h004, v); chk("R10 status", v, 32'hCAFE_0042);
    error_i = 32'h0000_0108;
    @(negedge clk);
    error_i = 32'd0;
    rd(12'h008, v); chk("R10 error sticky", v, 32'h0000_0108);
    wr(12'h008, 32'h0000_0008);
    rd(12'h008, v); chk("R10 error w1c", v, 32'h0000_0100);
    wr(12'h00C, 32'h8000_0005);
    rd(12'h00C, v); chk("R10 irq readback", v, 32'h8000_0005);
    chk("R10 irq port", irq_en_o, 32'h8000_0005);

    // R6 immediate reset
    wr(12'h000, 32'h8000_0003);
    all_default();
    chk("R6 core_rst high", {31'd0, core_rst_o}, 32'd1);
    check_outputs("R6 active default");
    wr(addr_of(3), 32'h5555_AAAA);
    sof_pulse();
    check_shadows("R6 writes ignored");
    check_outputs("R6 held");
    chk("R6 still held", {31'd0, core_rst_o}, 32'd1);
    wr(12'h000, 32'h0000_0003);
    chk("R6 released", {31'd0, core_rst_o}, 32'd0);
    rd(12'h000, v); chk("R6 ctrl after release", v, 32'd3);

    // R7 synchronized reset
    write_all(32'h7777_1111);
    sof_pulse();
    for (int i = 0; i < N; i++) exp_act[i] = exp_sh[i];
    wr(12'h000, 32'h4000_0003);
    rd(12'h000, v); chk("R7 armed readback", v, 32'h4000_0003);
    repeat (3) @(negedge clk);
    chk("R8 no fire while low", {31'd0, core_rst_o}, 32'd0);
    check_outputs("R8 values kept while low");
    vblank_i = 1'b1;
    @(negedge clk);
    all_default();
    chk("R7 pulse high", {31'd0, core_rst_o}, 32'd1);
    check_outputs("R7 active default");
    @(negedge clk);
    chk("R7 pulse one cycle", {31'd0, core_rst_o}, 32'd0);
    check_shadows("R7 shadow default");
    rd(12'h000, v); chk("R7 disarmed", v, 32'd3);

    // R8 arm while vblank already high
    write_all(32'h2468_ACE0);
    sof_pulse();
    for (int i = 0; i < N; i++) exp_act[i] = exp_sh[i];
    wr(12'h000, 32'h4000_0003);
    repeat (3) @(negedge clk);
    chk("R8 level does not fire", {31'd0, core_rst_o}, 32'd0);
    check_outputs("R8 values kept high");
    vblank_i = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 fall does not fire", {31'd0, core_rst_o}, 32'd0);
    rd(12'h000, v); chk("R8 still armed", v, 32'h4000_0003);
    vblank_i = 1'b1;
    @(negedge clk);
    all_default();
    chk("R8 fresh rise fires", {31'd0, core_rst_o}, 32'd1);
    check_outputs("R8 default after rise");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule